// File: doc/BRIEF.md
# Protection Fault Response Sequencer

This block decides what a switching converter does once any of its protection faults fires. It receives one fault flag, which is already the OR of every fault whose response is selectable. It drives a switching permit, a request that starts the soft-start ramp, and a status flag for a locked-out fault. One of two policies applies to each fault.

In retry mode, switching stops, a fixed pause is timed, and the converter restarts through a complete soft-start. This repeats for as long as the fault is present. In lock-out mode, switching stays off even after the fault clears. Only a low level on the enable input or a power-on-reset pulse releases the lock.

All pins are plain control and status levels. No data moves through the block, so there is no valid/ready interface. The pause length is the parameter `WAIT_CYCLES`. Its default equals 500 ms at a 200 MHz clock, and a bench can make it shorter.

Top module: `fault_resp_ctrl`

## Requirements
- R1: After `rst_n` is released, and in the cycle after any cycle with `por_i` high, all three outputs are low. From the idle state, `en_i` high starts a soft-start, so `ss_req_o` is high in the following cycle.
- R2: While soft-start is requested, both `ss_req_o` and `sw_en_o` are high as long as `fault_i` is low. When `ss_done_i` is sampled high in that state with no fault, enable or power-on-reset event pending, the block enters normal run: `ss_req_o` drops in the next cycle and `sw_en_o` stays high.
- R3: During soft-start or run, `sw_en_o` is low in the same cycle that `fault_i` is high, without waiting for a clock edge. A fault during soft-start is handled the same way as a fault during run.
- R4: If `hiccup_sel_i` is 1 (retry) when a fault is sampled, the block enters the retry pause with all outputs low and `latched_o` low. The pause lasts exactly `WAIT_CYCLES` cycles, and `ss_req_o` then rises.
- R5: The level of `fault_i` during the retry pause is ignored. If the fault is still present after the restart, another pause follows, and this repeats.
- R6: If `hiccup_sel_i` is 0 (lock-out) when a fault is sampled, `latched_o` goes high in the next cycle and `sw_en_o` stays low. The lock persists when the fault clears and when `hiccup_sel_i` changes.
- R7: The lock is released only by `en_i` low or `por_i` high. Either one returns the block to idle in the next cycle, and idle with `en_i` high then starts a new soft-start.
- R8: Priority from highest to lowest is `por_i`, then `en_i` low, then `fault_i`, then `ss_done_i`. `en_i` low forces idle from any state, including the retry pause, which then does not restart.
- R9: `ss_done_i` has no effect outside the soft-start state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| por_i | input | 1 | Power-on-reset event, synchronous clear to idle |
| en_i | input | 1 | Converter enable level |
| hiccup_sel_i | input | 1 | 1 = timed retry, 0 = lock-out |
| fault_i | input | 1 | OR of the selectable protection faults |
| ss_done_i | input | 1 | Soft-start ramp finished |
| sw_en_o | output | 1 | Switching permitted |
| ss_req_o | output | 1 | Soft-start ramp requested |
| latched_o | output | 1 | Locked-out fault status |

## Verification
The assertions assume that every input is synchronous to `clk` and is stable around the sampling edge. They also assume that a power-on-reset event and the enable level are sampled as single-cycle levels, with no glitches between edges. The bench changes inputs only 1 ns after a rising edge and compares at the falling edge. The directed part holds inputs through each scenario long enough to cover pauses and re-arms. The pseudo-random part keeps `por_i` rare and `en_i` mostly high, so that the retry pause and the lock both occur often and hold for many cycles.

// File: rtl/frc_pkg.sv
package frc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SOFT  = 3'd1,
    ST_RUN   = 3'd2,
    ST_PAUSE = 3'd3,
    ST_LOCK  = 3'd4
  } frc_state_t;

  function automatic logic is_switching(input frc_state_t s);
    return (s == ST_SOFT) || (s == ST_RUN);
  endfunction
endpackage

// File: rtl/frc_wait_timer.sv
module frc_wait_timer #(
  parameter int unsigned WAIT_CYCLES = 100_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  output logic expired
);
  localparam int unsigned CW = (WAIT_CYCLES > 1) ? $clog2(WAIT_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(WAIT_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  // Counter is held at zero outside the pause, so every pause is full length.
  assign expired = active && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (!active)
      cnt_q <= '0;
    else if (!expired)
      cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/frc_seq.sv
module frc_seq
  import frc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       por_i,
  input  logic       en_i,
  input  logic       hiccup_sel_i,
  input  logic       fault_i,
  input  logic       ss_done_i,
  input  logic       pause_done,
  output frc_state_t state
);
  frc_state_t nxt;
  frc_state_t trip_dest;

  // Where a fault leads depends on the policy chosen at the moment of trip.
  assign trip_dest = hiccup_sel_i ? ST_PAUSE : ST_LOCK;

  always_comb begin
    nxt = state;
    if (por_i) begin
      nxt = ST_IDLE;
    end else if (!en_i) begin
      nxt = ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE:  nxt = ST_SOFT;
        ST_SOFT:  begin
          if (fault_i)        nxt = trip_dest;
          else if (ss_done_i) nxt = ST_RUN;
        end
        ST_RUN:   if (fault_i) nxt = trip_dest;
        ST_PAUSE: if (pause_done) nxt = ST_SOFT;
        ST_LOCK:  nxt = ST_LOCK;
        default:  nxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end
endmodule

// File: rtl/frc_out.sv
module frc_out
  import frc_pkg::*;
(
  input  frc_state_t state,
  input  logic       fault_i,
  output logic       sw_en_o,
  output logic       ss_req_o,
  output logic       latched_o
);
  // The fault gates switching directly, so the stop does not wait for an edge.
  assign sw_en_o   = is_switching(state) && !fault_i;
  assign ss_req_o  = (state == ST_SOFT);
  assign latched_o = (state == ST_LOCK);
endmodule

// File: rtl/fault_resp_ctrl.sv
module fault_resp_ctrl #(
  parameter int unsigned WAIT_CYCLES = 100_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic por_i,
  input  logic en_i,
  input  logic hiccup_sel_i,
  input  logic fault_i,
  input  logic ss_done_i,
  output logic sw_en_o,
  output logic ss_req_o,
  output logic latched_o
);
  import frc_pkg::*;

  frc_state_t state;
  logic       pause_done;

  frc_wait_timer #(.WAIT_CYCLES(WAIT_CYCLES)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .active  (state == ST_PAUSE),
    .expired (pause_done)
  );

  frc_seq u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .por_i        (por_i),
    .en_i         (en_i),
    .hiccup_sel_i (hiccup_sel_i),
    .fault_i      (fault_i),
    .ss_done_i    (ss_done_i),
    .pause_done   (pause_done),
    .state        (state)
  );

  frc_out u_out (
    .state     (state),
    .fault_i   (fault_i),
    .sw_en_o   (sw_en_o),
    .ss_req_o  (ss_req_o),
    .latched_o (latched_o)
  );
endmodule

// File: rtl/fault_resp_ctrl_chk.sv
module fault_resp_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic por_i,
  input logic en_i,
  input logic hiccup_sel_i,
  input logic fault_i,
  input logic ss_done_i,
  input logic sw_en_o,
  input logic ss_req_o,
  input logic latched_o
);
  assert_por_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
    por_i |=> (!sw_en_o && !ss_req_o && !latched_o));

  assert_done_ends_softstart_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ss_req_o && ss_done_i && !fault_i && en_i && !por_i) |=> !ss_req_o);

  assert_fault_stops_switching_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fault_i |-> !sw_en_o);

  assert_retry_never_locks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_i && hiccup_sel_i && !latched_o) |=> !latched_o);

  assert_lock_needs_fault_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(latched_o) |-> ($past(fault_i) && !$past(hiccup_sel_i)));

  assert_lock_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (latched_o && en_i && !por_i) |=> (latched_o && !sw_en_o));

  assert_enable_low_idles_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (!sw_en_o && !ss_req_o && !latched_o));

  assert_lock_blocks_switching_R6: assert property (@(posedge clk) disable iff (!rst_n)
    latched_o |-> (!sw_en_o && !ss_req_o));
endmodule

bind fault_resp_ctrl fault_resp_ctrl_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .por_i        (por_i),
  .en_i         (en_i),
  .hiccup_sel_i (hiccup_sel_i),
  .fault_i      (fault_i),
  .ss_done_i    (ss_done_i),
  .sw_en_o      (sw_en_o),
  .ss_req_o     (ss_req_o),
  .latched_o    (latched_o)
);

// File: tb/fault_resp_ctrl_test.sv
`timescale 1ns/1ps
module fault_resp_ctrl_test;
  localparam int W = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic por_i = 1'b0, en_i = 1'b0, hiccup_sel_i = 1'b0, fault_i = 1'b0, ss_done_i = 1'b0;
  logic sw_en_o, ss_req_o, latched_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  fault_resp_ctrl #(.WAIT_CYCLES(W)) uut (
    .clk(clk), .rst_n(rst_n), .por_i(por_i), .en_i(en_i),
    .hiccup_sel_i(hiccup_sel_i), .fault_i(fault_i), .ss_done_i(ss_done_i),
    .sw_en_o(sw_en_o), .ss_req_o(ss_req_o), .latched_o(latched_o)
  );

  // Behavioural reference: 0 idle, 1 soft-start, 2 run, 3 pause, 4 locked.
  int m_mode = 0;
  int m_wait = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode <= 0;
      m_wait <= 0;
    end else if (por_i || !en_i) begin
      m_mode <= 0;
    end else if (m_mode == 0) begin
      m_mode <= 1;
    end else if (m_mode == 1 || m_mode == 2) begin
      if (fault_i) begin
        m_mode <= hiccup_sel_i ? 3 : 4;
        m_wait <= 0;
      end else if (m_mode == 1 && ss_done_i) begin
        m_mode <= 2;
      end
    end else if (m_mode == 3) begin
      if (m_wait + 1 >= W) m_mode <= 1;
      else                 m_wait <= m_wait + 1;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Every-cycle comparison against the reference at the falling edge.
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R3 model sw_en", int'(sw_en_o), int'((m_mode == 1 || m_mode == 2) && !fault_i));
      chk("R2 model ss_req", int'(ss_req_o), int'(m_mode == 1));
      chk("R6 model latched", int'(latched_o), int'(m_mode == 4));
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic outs(input string req, input int s, input int r, input int l);
    chk({req, " sw_en"}, int'(sw_en_o), s);
    chk({req, " ss_req"}, int'(ss_req_o), r);
    chk({req, " latched"}, int'(latched_o), l);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    outs("R1 reset", 0, 0, 0);

    en_i = 1'b1; step(1);
    outs("R1 start", 1, 1, 0);
    step(3);
    outs("R2 holding", 1, 1, 0);
    ss_done_i = 1'b1; step(1); ss_done_i = 1'b0;
    outs("R2 run", 1, 0, 0);
    ss_done_i = 1'b1; step(2); ss_done_i = 1'b0;
    outs("R9 done in run", 1, 0, 0);

    // Retry policy
    hiccup_sel_i = 1'b1; fault_i = 1'b1; #1;
    chk("R3 same-cycle stop", int'(sw_en_o), 0);
    step(1);
    outs("R4 pause entry", 0, 0, 0);
    step(W - 1);
    outs("R5 fault ignored in pause", 0, 0, 0);
    step(1);
    outs("R4 restart after pause", 0, 1, 0);
    step(1);
    outs("R5 repeat pause", 0, 0, 0);
    fault_i = 1'b0;
    step(W);
    outs("R5 second restart", 1, 1, 0);
    ss_done_i = 1'b1; step(1); ss_done_i = 1'b0;

    // Lock-out policy
    hiccup_sel_i = 1'b0; fault_i = 1'b1; step(1);
    outs("R6 locked", 0, 0, 1);
    fault_i = 1'b0; hiccup_sel_i = 1'b1; step(5);
    outs("R6 lock persists", 0, 0, 1);
    ss_done_i = 1'b1; step(2); ss_done_i = 1'b0;
    outs("R9 done in lock", 0, 0, 1);
    en_i = 1'b0; step(1);
    outs("R7 enable release", 0, 0, 0);
    en_i = 1'b1; step(1);
    outs("R7 rearm", 1, 1, 0);
    hiccup_sel_i = 1'b0; fault_i = 1'b1; step(1); fault_i = 1'b0;
    outs("R6 locked from soft-start", 0, 0, 1);
    por_i = 1'b1; step(1); por_i = 1'b0;
    outs("R7 por release", 0, 0, 0);
    step(1);
    outs("R7 por rearm", 1, 1, 0);

    // Enable low priority
    hiccup_sel_i = 1'b1; fault_i = 1'b1; step(1); fault_i = 1'b0;
    step(3);
    en_i = 1'b0; step(1);
    outs("R8 idle from pause", 0, 0, 0);
    step(W + 2);
    outs("R8 no restart", 0, 0, 0);
    en_i = 1'b1; step(1);
    en_i = 1'b0; hiccup_sel_i = 1'b0; fault_i = 1'b1; step(1);
    outs("R8 enable beats fault", 0, 0, 0);
    fault_i = 1'b0; en_i = 1'b1; por_i = 1'b1; step(1); por_i = 1'b0;
    outs("R8 por beats enable", 0, 0, 0);

    // Pseudo-random traffic checked by the reference every cycle
    for (int i = 0; i < 4000; i++) begin
      en_i         = ($urandom_range(0, 99) < 97);
      por_i        = ($urandom_range(0, 999) < 4);
      fault_i      = ($urandom_range(0, 99) < 6);
      hiccup_sel_i = ($urandom_range(0, 1) == 1);
      ss_done_i    = ($urandom_range(0, 99) < 20);
      step(1);
    end
    por_i = 1'b0; fault_i = 1'b0;
    step(2);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule